// File: doc/BRIEF.md
# Spectral Folding Decimator with Quarter-Band Derotation

This block turns one block of `NOS` frequency-domain bins from an over-sampled, already matched-filtered signal into `N` symbol-spaced bins (`NOS = ROS * N`, with ROS allowed to be fractional). It does not filter to decimate. Each input bin is read as a signed frequency and wrapped modulo `N`. The bins outside the symbol band therefore land on in-band bins and are added to them. Bins whose matched-filter coefficient is zero are named by a frequency limit `FMAX`. They are accepted but never enter the sum.

The undo of pi/2-rotation modulation, a cyclic shift of the frequency vector by N/4 bins, costs no arithmetic. The readout simply walks the accumulation memory from an offset address. Two accumulation banks alternate, so the next block can fold while the previous one streams out to the inverse transform. Each output word is rounded, scaled down and saturated before it leaves the block.

Both streams use valid/ready. An input bin transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` falls only when both banks hold complete blocks that have not been read out. An output bin transfers when `out_valid` and `out_ready` are both high. While `out_ready` is low, the offered output holds.

Top module: `fold_decim`

## Requirements
- R1: Output bin `k` of a block equals the rounded and saturated sum of every kept input bin whose signed frequency `f` satisfies `f mod N == a(k)`. Here `a(k)` is the memory address defined in R5. Output bins may be summed in any arrival order within the block.
- R2: An input at index `i` (0 to NOS-1) has signed frequency `f = i` when `i < NOS/2`, and `f = i - NOS` otherwise. A block ends after exactly NOS accepted input transfers.
- R3: An input bin with `|f| > FMAX` is accepted but has no effect on any output bin.
- R4: An output bin that no kept input maps to reads as zero. Values from an earlier block never leak into a later one.
- R5: With `ROT_DIR = SHIFT_DOWN`, output bin `k` carries address `(k - N/4) mod N`. With `SHIFT_UP`, it carries address `(k + N/4) mod N`.
- R6: Each block yields exactly N output transfers in order `k = 0 .. N-1`. `out_bin` equals `k`, and `out_last` is high only on `k = N-1`.
- R7: Each sum `s` is shifted down by `OUT_SHIFT` with rounding half up, computed as `(s + 2^(OUT_SHIFT-1)) >> OUT_SHIFT` arithmetically. The result is then clamped to the signed range of `OW` bits.
- R8: `in_ready` is low only when both banks hold unread complete blocks. With one bank free, a new block is accepted while the other bank is being read out.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_re`, `out_im`, `out_bin` and `out_last` hold their values.
- R10: After reset, `in_ready` is high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bin offered |
| in_ready | output | 1 | Input bin can be taken |
| in_idx | input | $clog2(NOS) | Index of the input bin within its block |
| in_re | input | W | Real part of the input bin, signed |
| in_im | input | W | Imaginary part of the input bin, signed |
| out_valid | output | 1 | Output bin offered |
| out_ready | input | 1 | Consumer takes the output bin |
| out_bin | output | $clog2(N) | Output bin number k |
| out_re | output | OW | Real part of the output bin, signed |
| out_im | output | OW | Imaginary part of the output bin, signed |
| out_last | output | 1 | Final bin of the output block |

## Verification
The bench builds the block with N=16 and NOS=20, a 1.25 over-sampling factor. With FMAX=9, the Nyquist bin f=-10 falls in the skipped region, and three output bins each receive two input bins. With W=12, OW=11 and OUT_SHIFT=1, both half-up rounding and clamping can be reached with full-scale inputs. Two instances with opposite `ROT_DIR` run side by side on the same stimulus. Single-bin blocks at every input index cover the whole index-to-address map, including the skipped index. Zero-leak between blocks is covered, and a stalled consumer fills both banks.

// File: rtl/fold_pkg.sv
package fold_pkg;

  // Direction of the quarter-band readout offset.
  typedef enum logic [0:0] {
    SHIFT_DOWN = 1'b0,
    SHIFT_UP   = 1'b1
  } rot_dir_e;

endpackage

// File: rtl/fold_addr_map.sv
module fold_addr_map #(
  parameter int N    = 16,
  parameter int NOS  = 20,
  parameter int FMAX = 9,
  localparam int LOGN = $clog2(N),
  localparam int IW   = $clog2(NOS)
) (
  input  logic [IW-1:0]   idx,
  output logic [LOGN-1:0] addr,
  output logic            keep
);

  localparam logic signed [IW+1:0] NOS_S = $signed((IW+2)'(NOS));

  logic signed [IW+1:0] freq;
  logic signed [IW+1:0] mag;

  // Signed frequency of the bin, then its magnitude for the skip test.
  always_comb begin
    freq = $signed({2'b00, idx});
    if (int'(idx) >= NOS / 2) freq = freq - NOS_S;
    mag = (freq < 0) ? -freq : freq;
  end

  // Two's-complement low bits give f mod N for power-of-two N.
  assign addr = freq[LOGN-1:0];
  assign keep = (int'(mag) <= FMAX);

endmodule

// File: rtl/fold_bank.sv
module fold_bank #(
  parameter int N  = 16,
  parameter int W  = 12,
  parameter int AW = 13,
  localparam int LOGN = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [LOGN-1:0]      wr_addr,
  input  logic signed [W-1:0]  wr_re,
  input  logic signed [W-1:0]  wr_im,
  input  logic                 clr,
  input  logic [LOGN-1:0]      rd_addr,
  output logic signed [AW-1:0] rd_re,
  output logic signed [AW-1:0] rd_im
);

  logic signed [AW-1:0] acc_re [N];
  logic signed [AW-1:0] acc_im [N];
  logic [N-1:0]         touched;

  logic signed [AW-1:0] add_re;
  logic signed [AW-1:0] add_im;

  assign add_re = AW'(wr_re);
  assign add_im = AW'(wr_im);

  // First hit on an address overwrites, later hits accumulate.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (touched[wr_addr]) begin
        acc_re[wr_addr] <= acc_re[wr_addr] + add_re;
        acc_im[wr_addr] <= acc_im[wr_addr] + add_im;
      end else begin
        acc_re[wr_addr] <= add_re;
        acc_im[wr_addr] <= add_im;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      touched <= '0;
    end else if (clr) begin
      touched <= '0;
    end else if (wr_en) begin
      touched[wr_addr] <= 1'b1;
    end
  end

  assign rd_re = touched[rd_addr] ? acc_re[rd_addr] : '0;
  assign rd_im = touched[rd_addr] ? acc_im[rd_addr] : '0;

endmodule

// File: rtl/fold_round_sat.sv
module fold_round_sat #(
  parameter int AW    = 13,
  parameter int OW    = 11,
  parameter int SHIFT = 1
) (
  input  logic signed [AW-1:0] din,
  output logic signed [OW-1:0] dout
);

  localparam logic signed [AW:0] MAXV = {{(AW + 2 - OW){1'b0}}, {(OW - 1){1'b1}}};
  localparam logic signed [AW:0] MINV = ~MAXV;

  logic signed [AW:0] scaled;

  generate
    if (SHIFT > 0) begin : g_round
      localparam logic signed [AW:0] HALF = $signed((AW+1)'(1) << (SHIFT - 1));
      logic signed [AW:0] biased;
      assign biased = (AW+1)'(din) + HALF;
      assign scaled = biased >>> SHIFT;
    end else begin : g_pass
      assign scaled = (AW+1)'(din);
    end
  endgenerate

  always_comb begin
    if (scaled > MAXV)      dout = MAXV[OW-1:0];
    else if (scaled < MINV) dout = MINV[OW-1:0];
    else                    dout = scaled[OW-1:0];
  end

endmodule

// File: rtl/fold_decim.sv
module fold_decim
  import fold_pkg::*;
#(
  parameter int       N         = 16,
  parameter int       NOS       = 20,
  parameter int       W         = 12,
  parameter int       OW        = 11,
  parameter int       OUT_SHIFT = 1,
  parameter int       FMAX      = 9,
  parameter rot_dir_e ROT_DIR   = SHIFT_DOWN,
  localparam int LOGN = $clog2(N),
  localparam int IW   = $clog2(NOS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [IW-1:0]        in_idx,
  input  logic signed [W-1:0]  in_re,
  input  logic signed [W-1:0]  in_im,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [LOGN-1:0]      out_bin,
  output logic signed [OW-1:0] out_re,
  output logic signed [OW-1:0] out_im,
  output logic                 out_last
);

  localparam int FOLDS = (NOS + N - 1) / N;
  localparam int GUARD = $clog2(FOLDS);
  localparam int AW    = W + GUARD;
  localparam logic [IW-1:0]   LAST_IN  = IW'(NOS - 1);
  localparam logic [LOGN-1:0] LAST_OUT = LOGN'(N - 1);
  localparam logic [LOGN-1:0] QOFF     = LOGN'(N / 4);

  logic            wb;
  logic            rb;
  logic [1:0]      full;
  logic [IW-1:0]   in_cnt;
  logic [LOGN-1:0] rd_k;
  logic [LOGN-1:0] rd_addr;
  logic [LOGN-1:0] map_addr;
  logic            map_keep;
  logic            in_fire;
  logic            out_fire;
  logic            in_done;
  logic            out_done;

  assign in_ready  = !full[wb];
  assign out_valid = full[rb];
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign in_done   = in_fire && (in_cnt == LAST_IN);
  assign out_done  = out_fire && (rd_k == LAST_OUT);

  fold_addr_map #(.N(N), .NOS(NOS), .FMAX(FMAX)) map_i (
    .idx  (in_idx),
    .addr (map_addr),
    .keep (map_keep)
  );

  // Bank sequencing: fill order and read order are the same.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb     <= 1'b0;
      rb     <= 1'b0;
      full   <= '0;
      in_cnt <= '0;
      rd_k   <= '0;
    end else begin
      if (in_fire)  in_cnt <= in_done ? '0 : in_cnt + 1'b1;
      if (in_done)  wb <= ~wb;
      if (out_fire) rd_k <= rd_k + 1'b1;
      if (out_done) rb <= ~rb;
      for (int b = 0; b < 2; b++) begin
        if (in_done && (wb == 1'(b)))        full[b] <= 1'b1;
        else if (out_done && (rb == 1'(b)))  full[b] <= 1'b0;
      end
    end
  end

  // Quarter-band derotation folded into the read address.
  generate
    if (ROT_DIR == SHIFT_DOWN) begin : g_rot_down
      assign rd_addr = rd_k - QOFF;
    end else begin : g_rot_up
      assign rd_addr = rd_k + QOFF;
    end
  endgenerate

  logic signed [AW-1:0] bank_re [2];
  logic signed [AW-1:0] bank_im [2];

  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank
      fold_bank #(.N(N), .W(W), .AW(AW)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_fire && map_keep && (wb == 1'(b))),
        .wr_addr (map_addr),
        .wr_re   (in_re),
        .wr_im   (in_im),
        .clr     (out_done && (rb == 1'(b))),
        .rd_addr (rd_addr),
        .rd_re   (bank_re[b]),
        .rd_im   (bank_im[b])
      );
    end
  endgenerate

  logic signed [AW-1:0] sel_re;
  logic signed [AW-1:0] sel_im;

  assign sel_re = rb ? bank_re[1] : bank_re[0];
  assign sel_im = rb ? bank_im[1] : bank_im[0];

  fold_round_sat #(.AW(AW), .OW(OW), .SHIFT(OUT_SHIFT)) fmt_re_i (
    .din  (sel_re),
    .dout (out_re)
  );

  fold_round_sat #(.AW(AW), .OW(OW), .SHIFT(OUT_SHIFT)) fmt_im_i (
    .din  (sel_im),
    .dout (out_im)
  );

  assign out_bin  = rd_k;
  assign out_last = (rd_k == LAST_OUT);

endmodule

// File: rtl/fold_decim_chk.sv
module fold_decim_chk #(
  parameter int N  = 16,
  parameter int OW = 11,
  localparam int LOGN = $clog2(N)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [LOGN-1:0]      out_bin,
  input logic signed [OW-1:0] out_re,
  input logic signed [OW-1:0] out_im,
  input logic                 out_last
);

  // Independent count of output transfers within a block.
  int unsigned seen;

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 0;
    else if (out_valid && out_ready) seen <= (seen == N - 1) ? 0 : seen + 1;
  end

  p_last_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (seen == N - 1)));

  p_bin_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_bin) == seen));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)
                                   && $stable(out_bin) && $stable(out_last)));

  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_reset_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (in_ready && !out_valid));

endmodule

bind fold_decim fold_decim_chk #(.N(N), .OW(OW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bin   (out_bin),
  .out_re    (out_re),
  .out_im    (out_im),
  .out_last  (out_last)
);

// File: tb/fold_decim_tb_top.sv
module fold_decim_tb_top;
  import fold_pkg::*;

  localparam int N    = 16;
  localparam int NOS  = 20;
  localparam int W    = 12;
  localparam int OW   = 11;
  localparam int SH   = 1;
  localparam int FMAX = 9;
  localparam int LOGN = $clog2(N);
  localparam int IW   = $clog2(NOS);
  localparam int NBLK = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [IW-1:0] in_idx = '0;
  logic signed [W-1:0] in_re = '0;
  logic signed [W-1:0] in_im = '0;
  logic out_ready = 1'b0;

  logic in_ready, out_valid, out_last;
  logic [LOGN-1:0] out_bin;
  logic signed [OW-1:0] out_re, out_im;
  logic in_ready_u, out_valid_u, out_last_u;
  logic [LOGN-1:0] out_bin_u;
  logic signed [OW-1:0] out_re_u, out_im_u;

  always #4 clk = ~clk;

  fold_decim #(.N(N), .NOS(NOS), .W(W), .OW(OW), .OUT_SHIFT(SH), .FMAX(FMAX),
               .ROT_DIR(SHIFT_DOWN)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_idx(in_idx), .in_re(in_re), .in_im(in_im), .out_valid(out_valid),
    .out_ready(out_ready), .out_bin(out_bin), .out_re(out_re), .out_im(out_im),
    .out_last(out_last));

  fold_decim #(.N(N), .NOS(NOS), .W(W), .OW(OW), .OUT_SHIFT(SH), .FMAX(FMAX),
               .ROT_DIR(SHIFT_UP)) dut_up_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_u),
    .in_idx(in_idx), .in_re(in_re), .in_im(in_im), .out_valid(out_valid_u),
    .out_ready(out_ready), .out_bin(out_bin_u), .out_re(out_re_u), .out_im(out_im_u),
    .out_last(out_last_u));

  int checks = 0;
  int failures = 0;
  int blk_re [NBLK][NOS];
  int blk_im [NBLK][NOS];
  string blk_tag [NBLK];
  int sent = 0;
  int blk_out = 0;
  int kpos = 0;
  bit stall = 1'b0;
  bit throttle = 1'b0;
  int cyc = 0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (block %0d bin %0d)", req, act, exp, blk_out, kpos);
    end
  endtask

  function automatic int rnd(input int span);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[30:16] % 15'(2 * span)) - span;
  endfunction

  // Model: signed frequency, skip region, fold modulo N, offset readout, round, clamp.
  function automatic int model(input int b, input int k, input bit up, input bit im);
    int addr, s, f, q, lim;
    addr = up ? (k + N / 4) % N : (k - N / 4 + N) % N;
    s = 0;
    for (int i = 0; i < NOS; i++) begin
      f = (i < NOS / 2) ? i : i - NOS;
      if (f > FMAX || f < -FMAX) continue;
      if (((f % N) + N) % N == addr) s += im ? blk_im[b][i] : blk_re[b][i];
    end
    q = (SH > 0) ? ((s + (1 << (SH - 1))) >>> SH) : s;
    lim = 1 << (OW - 1);
    if (q > lim - 1) q = lim - 1;
    if (q < -lim) q = -lim;
    return q;
  endfunction

  task automatic send_block(input int step, input bit gaps);
    for (int i = 0; i < NOS; i++) begin
      int ix;
      ix = (i * step) % NOS;
      @(negedge clk);
      in_valid = 1'b1;
      in_idx = IW'(ix);
      in_re = W'(blk_re[sent][ix]);
      in_im = W'(blk_im[sent][ix]);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      if (gaps && (i % 2 == 1)) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    sent++;
  endtask

  // Output side: drive ready and check every transfer.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = stall ? 1'b0 : (throttle ? (cyc % 3 != 0) : 1'b1);
      if (out_valid && out_ready && rst_n) begin
        int e;
        e = model(blk_out, kpos, 1'b0, 1'b0);
        check(int'(out_re) == e, (e == 0) ? "R4" : blk_tag[blk_out], int'(out_re), e);
        e = model(blk_out, kpos, 1'b0, 1'b1);
        check(int'(out_im) == e, (e == 0) ? "R4" : blk_tag[blk_out], int'(out_im), e);
        e = model(blk_out, kpos, 1'b1, 1'b0);
        check(out_valid_u && int'(out_re_u) == e, "R5", int'(out_re_u), e);
        e = model(blk_out, kpos, 1'b1, 1'b1);
        check(int'(out_im_u) == e, "R5", int'(out_im_u), e);
        check(int'(out_bin) == kpos, "R6", int'(out_bin), kpos);
        check(out_last == (kpos == N - 1), "R6", int'(out_last), int'(kpos == N - 1));
        if (kpos == N - 1) begin
          kpos = 0;
          blk_out++;
        end else begin
          kpos++;
        end
      end
    end
  end

  task automatic run_all();
    // R10: state right after reset
    @(negedge clk);
    check(in_ready == 1'b1, "R10", int'(in_ready), 1);
    check(out_valid == 1'b0, "R10", int'(out_valid), 0);

    // Single-bin blocks at every index (R2 map, R3 skipped index).
    for (int j = 0; j < NOS; j++) begin
      for (int i = 0; i < NOS; i++) begin
        blk_re[j][i] = (i == j) ? 101 + 6 * j : 0;
        blk_im[j][i] = (i == j) ? -(51 + 4 * j) : 0;
      end
      blk_tag[j] = (j == NOS / 2) ? "R3" : "R2";
      send_block(1, j % 4 == 3);
    end

    // Full random block, permuted arrival order, throttled consumer (R1).
    throttle = 1'b1;
    for (int i = 0; i < NOS; i++) begin
      blk_re[20][i] = rnd(2048);
      blk_im[20][i] = rnd(2048);
    end
    blk_tag[20] = "R1";
    send_block(3, 1'b0);

    // Small odd and negative values: rounding half up (R7).
    for (int i = 0; i < NOS; i++) begin
      blk_re[21][i] = rnd(8);
      blk_im[21][i] = -(i % 4) - 1;
    end
    blk_tag[21] = "R7";
    send_block(1, 1'b1);

    // Full-scale inputs: clamp at both ends (R7).
    for (int i = 0; i < NOS; i++) begin
      blk_re[22][i] = 2047;
      blk_im[22][i] = -2048;
    end
    blk_tag[22] = "R7";
    send_block(7, 1'b0);
    throttle = 1'b0;

    wait (blk_out == sent);

    // Stalled consumer: both banks fill (R8), offered output holds (R9).
    stall = 1'b1;
    for (int b = 23; b < 25; b++) begin
      for (int i = 0; i < NOS; i++) begin
        blk_re[b][i] = rnd(1500);
        blk_im[b][i] = rnd(1500);
      end
      blk_tag[b] = "R1";
    end
    send_block(1, 1'b0);
    @(negedge clk);
    check(in_ready == 1'b1, "R8", int'(in_ready), 1);
    send_block(3, 1'b0);
    @(negedge clk);
    check(in_ready == 1'b0, "R8", int'(in_ready), 0);
    check(out_valid == 1'b1, "R8", int'(out_valid), 1);
    begin
      int hold_re, hold_im;
      hold_re = int'(out_re);
      hold_im = int'(out_im);
      repeat (4) @(negedge clk);
      check(int'(out_re) == hold_re, "R9", int'(out_re), hold_re);
      check(int'(out_im) == hold_im, "R9", int'(out_im), hold_im);
      check(out_valid == 1'b1 && out_bin == '0, "R9", int'(out_bin), 0);
    end
    stall = 1'b0;
    wait (blk_out == sent);
    @(negedge clk);
    check(blk_out == NBLK, "R6", blk_out, NBLK);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R8", int'(in_ready), 1);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    if (timed_out) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=expired expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule